// File: doc/BRIEF.md
# FIFO Assist Cache Buffer

This block is a small, fully associative line buffer that sits beside a main L1 data cache. Every line returned by memory after a miss is placed here first, never straight into L1. The processor looks up the buffer in the same cycle as L1. A hit returns the line combinationally, and a store hit overwrites the line and marks it dirty.

Replacement is strict first-in, first-out. Hits never change the age order. When the buffer is full, a new fill pushes out the oldest line, and a one-bit hint captured at fill time decides where that line goes. A line filled without the hint is offered to L1 for promotion. A line filled with the hint (data with spatial but no temporal reuse) bypasses L1. If it is dirty it is offered to memory for write-back; if it is clean it is simply dropped. Both outbound paths use valid/ready handshakes, and a fill waits until the outgoing line has been accepted.

The filler must hold a fill request stable until it is accepted. It must also never fill a tag that is already present in the buffer.

Top module: `assist_fifo_buf`

## Requirements
- R1: After reset the buffer is empty: no lookup hits, `fill_ready` is 1, and `pro_valid` and `wb_valid` are 0.
- R2: While the buffer holds fewer than ENTRIES lines, a fill is accepted in the cycle it is requested (`fill_ready`=1). From the next cycle on, a lookup of its tag returns `lk_hit`=1 and the filled data in the same cycle.
- R3: A lookup of a tag that is not held returns `lk_hit`=0.
- R4: A lookup with `lk_wr`=1 that hits replaces the line with `lk_wdata` and marks it dirty. Later reads and the line's eventual eviction carry the new data and the dirty flag (`pro_dirty`=1 or a write-back).
- R5: When the buffer is full, a fill evicts the line that was filled earliest. Lookup hits do not change this order.
- R6: An evicted line whose hint was 0 is offered on the promote port (`pro_valid`=1) with its tag, data and dirty flag.
- R7: An evicted line whose hint was 1 is offered on the write-back port if dirty. If clean, it is dropped with no output, and the fill is accepted in that cycle.
- R8: While an offered eviction is not accepted, `fill_ready` stays 0 and the buffer contents are unchanged, so the outgoing line still hits.
- R9: If a lookup write hits the oldest line in the same cycle that a fill would evict it, the fill is held (`fill_ready`=0) and no eviction is offered that cycle.
- R10: Without a fill request, or while the buffer is not full, `pro_valid` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is a full-line store |
| lk_tag | input | TAG_BITS | Lookup line tag |
| lk_wdata | input | LINE_BITS | Store data |
| lk_hit | output | 1 | Lookup found the tag |
| lk_rdata | output | LINE_BITS | Line data on a hit |
| fill_valid | input | 1 | Fill request from memory |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_tag | input | TAG_BITS | Fill line tag |
| fill_data | input | LINE_BITS | Fill line data |
| fill_hint | input | 1 | 1: bypass L1 on eviction |
| pro_valid | output | 1 | Promotion to L1 offered |
| pro_ready | input | 1 | L1 accepts promotion |
| pro_tag | output | TAG_BITS | Promoted line tag |
| pro_data | output | LINE_BITS | Promoted line data |
| pro_dirty | output | 1 | Promoted line is dirty |
| wb_valid | output | 1 | Write-back to memory offered |
| wb_ready | input | 1 | Memory accepts write-back |
| wb_tag | output | TAG_BITS | Write-back tag |
| wb_data | output | LINE_BITS | Write-back data |

## Verification
The risky overlap is a store lookup landing on the oldest line in the same cycle that a fill on a full buffer wants to push that line out. The bench provokes it by holding a fill while a store lookup to the oldest tag is driven in the same cycle. It expects `fill_ready` and `pro_valid` to be low during the overlap. It then expects the promoted line, once offered, to carry the stored data with the dirty flag set, so that no store is lost to the eviction. A second overlap, a read of the outgoing line while its eviction is stalled, is judged by a hit with the old data.

// File: rtl/assist_fifo_buf.sv
module assist_fifo_buf #(
  parameter int ENTRIES   = 64,
  parameter int TAG_BITS  = 27,
  parameter int LINE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic                 lk_wr,
  input  logic [TAG_BITS-1:0]  lk_tag,
  input  logic [LINE_BITS-1:0] lk_wdata,
  output logic                 lk_hit,
  output logic [LINE_BITS-1:0] lk_rdata,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  input  logic [TAG_BITS-1:0]  fill_tag,
  input  logic [LINE_BITS-1:0] fill_data,
  input  logic                 fill_hint,
  output logic                 pro_valid,
  input  logic                 pro_ready,
  output logic [TAG_BITS-1:0]  pro_tag,
  output logic [LINE_BITS-1:0] pro_data,
  output logic                 pro_dirty,
  output logic                 wb_valid,
  input  logic                 wb_ready,
  output logic [TAG_BITS-1:0]  wb_tag,
  output logic [LINE_BITS-1:0] wb_data
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = $clog2(ENTRIES + 1);
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(ENTRIES);

  logic [TAG_BITS-1:0]  tag_q  [ENTRIES];
  logic [LINE_BITS-1:0] data_q [ENTRIES];
  logic [ENTRIES-1:0]   vld_q, hint_q, dirty_q;
  logic [PW-1:0]        head_q, tail_q;
  logic [CW-1:0]        cnt_q;

  logic [ENTRIES-1:0] match;
  logic [PW-1:0]      hit_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cam
    assign match[i] = vld_q[i] && (tag_q[i] == lk_tag) && lk_valid;
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = PW'(i);
  end

  assign lk_hit   = |match;
  assign lk_rdata = data_q[hit_idx];

  logic full, conflict, go, head_hint, head_dirty, evict_ok, fill_fire, wr_hit;

  assign full       = (cnt_q == FULL_CNT);
  assign wr_hit     = lk_valid && lk_wr && lk_hit;
  assign conflict   = full && lk_wr && match[head_q];
  assign go         = fill_valid && full && !conflict;
  assign head_hint  = hint_q[head_q];
  assign head_dirty = dirty_q[head_q];

  assign pro_valid = go && !head_hint;
  assign pro_tag   = tag_q[head_q];
  assign pro_data  = data_q[head_q];
  assign pro_dirty = head_dirty;

  assign wb_valid = go && head_hint && head_dirty;
  assign wb_tag   = tag_q[head_q];
  assign wb_data  = data_q[head_q];

  assign evict_ok   = head_hint ? (!head_dirty || wb_ready) : pro_ready;
  assign fill_ready = !full || (!conflict && evict_ok);
  assign fill_fire  = fill_valid && fill_ready;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      hint_q  <= '0;
      dirty_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_hit) dirty_q[hit_idx] <= 1'b1;
      if (fill_fire) begin
        vld_q[tail_q]   <= 1'b1;
        hint_q[tail_q]  <= fill_hint;
        dirty_q[tail_q] <= 1'b0;
        tail_q          <= nxt(tail_q);
        if (full) head_q <= nxt(head_q);
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) data_q[hit_idx] <= lk_wdata;
    if (fill_fire) begin
      tag_q[tail_q]  <= fill_tag;
      data_q[tail_q] <= fill_data;
    end
  end
endmodule

module assist_fifo_buf_chk #(
  parameter int ENTRIES  = 64,
  parameter int TAG_BITS = 27
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_valid,
  input logic                lk_wr,
  input logic                fill_valid,
  input logic                fill_ready,
  input logic                pro_valid,
  input logic                pro_ready,
  input logic [TAG_BITS-1:0] pro_tag,
  input logic                wb_valid,
  input logic                wb_ready,
  input logic [ENTRIES-1:0]  match,
  input logic [$clog2(ENTRIES > 1 ? ENTRIES : 2)-1:0] head_q
);
  localparam int CW = $clog2(ENTRIES + 1);
  logic [CW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) occ <= '0;
    else if (fill_valid && fill_ready && occ != CW'(ENTRIES)) occ <= occ + 1'b1;

  // R3
  cam_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));

  // R6
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pro_valid && wb_valid));

  // R10
  no_early_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != CW'(ENTRIES) || !fill_valid) |-> !(pro_valid || wb_valid));

  // R2
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != CW'(ENTRIES) && fill_valid) |-> fill_ready);

  // R8
  pro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pro_valid && !pro_ready) |=> $stable(pro_tag));

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pro_valid && !pro_ready) || (wb_valid && !wb_ready)) |-> !fill_ready);

  // R9
  head_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(ENTRIES) && lk_valid && lk_wr && match[head_q]) |-> !(fill_ready || pro_valid || wb_valid));
endmodule

bind assist_fifo_buf assist_fifo_buf_chk #(.ENTRIES(ENTRIES), .TAG_BITS(TAG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_wr(lk_wr),
  .fill_valid(fill_valid), .fill_ready(fill_ready),
  .pro_valid(pro_valid), .pro_ready(pro_ready), .pro_tag(pro_tag),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .match(match), .head_q(head_q)
);

// File: tb/assist_fifo_buf_tb.sv
module assist_fifo_buf_tb;
  localparam int N = 4, TB = 8, LB = 32;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_wr = 0;
  logic [TB-1:0] lk_tag = 0;
  logic [LB-1:0] lk_wdata = 0;
  logic lk_hit;
  logic [LB-1:0] lk_rdata;
  logic fill_valid = 0, fill_ready, fill_hint = 0;
  logic [TB-1:0] fill_tag = 0;
  logic [LB-1:0] fill_data = 0;
  logic pro_valid, pro_ready = 0, pro_dirty;
  logic [TB-1:0] pro_tag;
  logic [LB-1:0] pro_data;
  logic wb_valid, wb_ready = 0;
  logic [TB-1:0] wb_tag;
  logic [LB-1:0] wb_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assist_fifo_buf #(.ENTRIES(N), .TAG_BITS(TB), .LINE_BITS(LB)) u_dut (.*);

  task automatic chk(input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [TB-1:0] t, input logic wr, input logic [LB-1:0] wd,
                      input logic eh, input logic [LB-1:0] ed, input string req);
    @(negedge clk);
    lk_valid = 1; lk_tag = t; lk_wr = wr; lk_wdata = wd;
    #1;
    chk(req, LB'(lk_hit), LB'(eh));
    if (eh && !wr) chk(req, lk_rdata, ed);
    @(posedge clk); #1;
    lk_valid = 0; lk_wr = 0;
  endtask

  task automatic fill_free(input logic [TB-1:0] t, input logic h);
    @(negedge clk);
    fill_valid = 1; fill_tag = t; fill_data = {4{t}}; fill_hint = h;
    #1;
    chk("R2 ready", LB'(fill_ready), 1);
    chk("R10 quiet", LB'({pro_valid, wb_valid}), 0);
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  typedef struct packed {
    logic          wr;
    logic [TB-1:0] tag;
    logic [LB-1:0] wd;
    logic          eh;
    logic [LB-1:0] ed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'h11, 32'h0,        1'b1, 32'h11111111},
    '{1'b0, 8'h99, 32'h0,        1'b0, 32'h0},
    '{1'b1, 8'h12, 32'hDEAD0012, 1'b1, 32'h0},
    '{1'b0, 8'h12, 32'h0,        1'b1, 32'hDEAD0012},
    '{1'b0, 8'h10, 32'h0,        1'b1, 32'h10101010},
    '{1'b0, 8'h13, 32'h0,        1'b1, 32'h13131313}
  };

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 fill_ready", LB'(fill_ready), 1);
    chk("R1 evict idle", LB'({pro_valid, wb_valid}), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    look(8'h05, 0, 0, 0, 0, "R1 empty miss");

    fill_free(8'h10, 0);
    fill_free(8'h11, 1);
    fill_free(8'h12, 1);
    fill_free(8'h13, 0);

    // R2 R3 R4 R5: lookup table
    for (int i = 0; i < 6; i++)
      look(VECS[i].tag, VECS[i].wr, VECS[i].wd, VECS[i].eh, VECS[i].ed, "R2/R3/R4 table");

    // R9: store to the oldest line while a fill waits
    @(negedge clk);
    fill_valid = 1; fill_tag = 8'h20; fill_data = 32'h20202020; fill_hint = 0;
    lk_valid = 1; lk_wr = 1; lk_tag = 8'h10; lk_wdata = 32'hBEEF0010;
    pro_ready = 1;
    #1;
    chk("R9 fill held", LB'(fill_ready), 0);
    chk("R9 no offer", LB'(pro_valid), 0);
    @(negedge clk);
    lk_wr = 0; pro_ready = 0;
    #1;
    chk("R5 oldest", LB'(pro_tag), LB'(8'h10));
    chk("R6 offer", LB'(pro_valid), 1);
    chk("R4 data", pro_data, 32'hBEEF0010);
    chk("R4 dirty", LB'(pro_dirty), 1);
    chk("R8 stall", LB'(fill_ready), 0);
    chk("R8 still hits", lk_rdata, 32'hBEEF0010);
    chk("R8 hit", LB'(lk_hit), 1);
    @(negedge clk);
    lk_valid = 0; pro_ready = 1;
    #1 chk("R6 accept", LB'(fill_ready), 1);
    @(posedge clk); #1;
    fill_valid = 0; pro_ready = 0;
    look(8'h10, 0, 0, 0, 0, "R5 evicted gone");
    look(8'h20, 0, 0, 1, 32'h20202020, "R2 new line");

    // R7 clean bypass drops
    @(negedge clk);
    fill_valid = 1; fill_tag = 8'h21; fill_data = 32'h21212121; fill_hint = 0;
    #1;
    chk("R7 drop ready", LB'(fill_ready), 1);
    chk("R7 drop silent", LB'({pro_valid, wb_valid}), 0);
    @(posedge clk); #1 fill_valid = 0;
    look(8'h11, 0, 0, 0, 0, "R7 dropped");

    // R7 dirty bypass writes back
    @(negedge clk);
    fill_valid = 1; fill_tag = 8'h22; fill_data = 32'h22222222; fill_hint = 1;
    #1;
    chk("R7 wb offer", LB'(wb_valid), 1);
    chk("R7 wb tag", LB'(wb_tag), LB'(8'h12));
    chk("R7 wb data", wb_data, 32'hDEAD0012);
    chk("R8 wb stall", LB'(fill_ready), 0);
    @(negedge clk);
    wb_ready = 1;
    #1 chk("R7 wb accept", LB'(fill_ready), 1);
    @(posedge clk); #1;
    fill_valid = 0; wb_ready = 0;

    // R6 clean promote
    @(negedge clk);
    fill_valid = 1; fill_tag = 8'h23; fill_data = 32'h23232323; fill_hint = 0;
    pro_ready = 1;
    #1;
    chk("R6 tag", LB'(pro_tag), LB'(8'h13));
    chk("R6 clean", LB'(pro_dirty), 0);
    chk("R6 valid", LB'(pro_valid), 1);
    @(posedge clk); #1;
    fill_valid = 0; pro_ready = 0;

    // R10 full, no request
    @(negedge clk); #1;
    chk("R10 idle full", LB'({pro_valid, wb_valid}), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule